// File: doc/BRIEF.md
# Per-Sink Trace ID Filter

This block sits between one trace source stream and two trace sinks. Each sink owns a 128-bit permission bitmap indexed directly by the 7-bit trace ID. A trace beat is offered to a sink only when that sink's bitmap bit for the beat's ID is set. Beats that no sink accepts are discarded without back-pressure. Reserved IDs are never forwarded, whatever their bitmap bits hold.

Bitmaps change in two ways. The first is a small register port that reads or overwrites whole 32-bit words. The second is a command port that enables or disables one ID on one sink. Each (sink, ID) pair has an 8-bit reference count, so several producers can share one ID on one sink. The bit stays set until the last of them disables it.

Top module: `trace_id_filter`

## Requirements
- R1: After reset every bitmap word reads 0, `err_flag` is 0, and a valid beat of any ID is dropped with `in_ready` high and no `out_valid` bit set.
- R2: Register address `a` selects sink `a[2]` and word `k = a[1:0]`. Bit `j` of that word is the permission for trace ID `32*k + j`. A write replaces the whole word. `reg_rdata` returns the addressed word in the same cycle.
- R3: A valid beat sets `out_valid[s]` exactly when sink `s` has the beat's ID bit set, the ID is not reserved, and the transfer completes. `out_id` and `out_data` carry the beat unchanged.
- R4: When an ID is permitted on both sinks, a beat with that ID raises both `out_valid` bits in the same cycle.
- R5: `in_ready` is low only while some sink that would accept the current beat has `out_ready` low. A beat that no sink accepts never stalls the input.
- R6: An enable command (`cmd_op`=1) for sink `cmd_sink` and ID `cmd_id` sets that one bitmap bit and leaves all other bits unchanged. It increments the pair's count, which saturates at 255. The effect is visible one cycle after the command.
- R7: A disable command (`cmd_op`=0) on a non-zero count decrements the count. The bitmap bit clears only when the count goes from 1 to 0. No other bit changes.
- R8: A disable command on a zero count leaves the bitmap unchanged and sets `err_flag`, which stays high until reset.
- R9: Trace ID 0 and IDs 0x70 through 0x7F are never forwarded to any sink and never stall the input.
- R10: Register writes change bitmap bits but not reference counts.
- R11: When a command and a register write address the same word in one cycle, the word takes the written value. The command's count update still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word select: sink in the top bit, word in the low bits |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Addressed word, combinational |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 1 = enable, 0 = disable |
| cmd_sink | input | 1 | Target sink |
| cmd_id | input | 7 | Target trace ID |
| err_flag | output | 1 | Sticky error: disable on a zero count |
| in_valid | input | 1 | Trace beat valid |
| in_ready | output | 1 | Trace beat accepted |
| in_id | input | 7 | Trace ID of the beat |
| in_data | input | 32 | Beat payload |
| out_valid | output | 2 | Per-sink beat valid |
| out_ready | input | 2 | Per-sink ready |
| out_id | output | 7 | Forwarded trace ID, shared by both sinks |
| out_data | output | 32 | Forwarded payload, shared by both sinks |

## Verification
The assertions assume that `cmd_valid` and `reg_we` are single-cycle strobes with stable operands at the clock edge. They also assume the bitmap checks compare only cycles without a register write to the touched word. The bench drives every strobe for exactly one cycle, at the falling edge. It overlaps a command with a write to the same word only in the one directed case built for that purpose. Its beats hold `in_id` and `out_ready` constant for a full cycle, so the combinational handshake is always sampled settled.

// File: rtl/tidf_pkg.sv
package tidf_pkg;
   typedef enum logic {
      OP_DISABLE = 1'b0,
      OP_ENABLE  = 1'b1
   } tidf_op_e;
endpackage

// File: rtl/tidf_sink_bank.sv
module tidf_sink_bank #(
   parameter int NUM_IDS = 128,
   parameter int REG_W   = 32,
   parameter int CNT_W   = 8,
   localparam int ID_W      = $clog2(NUM_IDS),
   localparam int NUM_WORDS = NUM_IDS / REG_W,
   localparam int WSEL_W    = $clog2(NUM_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_hit,
   input  logic               cmd_en,
   input  logic [ID_W-1:0]    cmd_id,
   input  logic               wr_hit,
   input  logic [WSEL_W-1:0]  wr_word,
   input  logic [REG_W-1:0]   wr_data,
   output logic [NUM_IDS-1:0] map,
   output logic               err_pulse
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [NUM_IDS-1:0] map_q, map_d;
   logic [CNT_W-1:0]   cnt_q [NUM_IDS];
   logic [CNT_W-1:0]   cur_cnt;
   logic               wr_same;

   initial assert (NUM_WORDS * REG_W == NUM_IDS && NUM_WORDS >= 2)
      else $fatal(1, "tidf_sink_bank: NUM_IDS must be a multiple of REG_W");

   assign cur_cnt   = cnt_q[cmd_id];
   assign err_pulse = cmd_hit && !cmd_en && (cur_cnt == '0);
   assign wr_same   = wr_hit && (wr_word == cmd_id[ID_W-1 -: WSEL_W]);
   assign map       = map_q;

   always_comb begin
      map_d = map_q;
      if (cmd_hit) begin
         if (cmd_en)
            map_d[cmd_id] = 1'b1;
         else if (cur_cnt == CNT_W'(1))
            map_d[cmd_id] = 1'b0;
      end
      if (wr_hit)
         map_d[wr_word*REG_W +: REG_W] = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q <= '0;
         for (int i = 0; i < NUM_IDS; i++)
            cnt_q[i] <= '0;
      end else begin
         map_q <= map_d;
         if (cmd_hit) begin
            if (cmd_en && cur_cnt != CNT_MAX)
               cnt_q[cmd_id] <= cur_cnt + CNT_W'(1);
            else if (!cmd_en && cur_cnt != '0)
               cnt_q[cmd_id] <= cur_cnt - CNT_W'(1);
         end
      end
   end

   // R6: an enable sets its bit
   p_enable_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && cmd_en && !wr_same |=> map_q[$past(cmd_id)]);

   // R6: the count saturates instead of wrapping
   p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && cmd_en && cur_cnt == CNT_MAX |=> cnt_q[$past(cmd_id)] == CNT_MAX);

   // R7: a disable above count 1 keeps the bit
   p_hold_above_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && !cmd_en && cur_cnt > CNT_W'(1) && !wr_same && map_q[cmd_id]
      |=> map_q[$past(cmd_id)]);

   // R8: a disable on a zero count leaves the bitmap alone
   p_zero_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse && !wr_hit |=> $stable(map_q));
endmodule

// File: rtl/tidf_fork.sv
module tidf_fork #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [N-1:0] pass,
   input  logic [N-1:0] out_ready,
   output logic         in_ready,
   output logic [N-1:0] out_valid
);
   initial assert (N >= 1) else $fatal(1, "tidf_fork: N must be positive");

   // the beat moves only when every accepting sink is ready, so no sink sees it twice
   assign in_ready  = &(~pass | out_ready);
   assign out_valid = {N{in_valid && in_ready}} & pass;

   // R5: a beat nobody accepts is never stalled
   p_drop_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && pass == '0 |-> in_ready);

   // R5: a sink only gets valid while it is ready
   p_valid_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid & ~out_ready) == '0);
endmodule

// File: rtl/trace_id_filter.sv
module trace_id_filter #(
   parameter int NUM_SINKS = 2,
   parameter int NUM_IDS   = 128,
   parameter int REG_W     = 32,
   parameter int CNT_W     = 8,
   parameter int DATA_W    = 32,
   parameter int RSV_HI    = 16,
   localparam int ID_W      = $clog2(NUM_IDS),
   localparam int NUM_WORDS = NUM_IDS / REG_W,
   localparam int WSEL_W    = $clog2(NUM_WORDS),
   localparam int SINK_W    = $clog2(NUM_SINKS),
   localparam int ADDR_W    = SINK_W + WSEL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic                 cmd_valid,
   input  logic                 cmd_op,
   input  logic [SINK_W-1:0]    cmd_sink,
   input  logic [ID_W-1:0]      cmd_id,
   output logic                 err_flag,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [ID_W-1:0]      in_id,
   input  logic [DATA_W-1:0]    in_data,
   output logic [NUM_SINKS-1:0] out_valid,
   input  logic [NUM_SINKS-1:0] out_ready,
   output logic [ID_W-1:0]      out_id,
   output logic [DATA_W-1:0]    out_data
);
   import tidf_pkg::*;

   localparam logic [ID_W-1:0] RSV_BASE = ID_W'(NUM_IDS - RSV_HI);

   logic [NUM_IDS-1:0]   map_s [NUM_SINKS];
   logic [NUM_SINKS-1:0] err_s;
   logic [NUM_SINKS-1:0] pass;
   logic                 rsv;
   logic                 err_q;
   logic [SINK_W-1:0]    rd_sink;
   logic [WSEL_W-1:0]    rd_word;

   initial assert (NUM_SINKS >= 2 && (1 << SINK_W) == NUM_SINKS && RSV_HI < NUM_IDS)
      else $fatal(1, "trace_id_filter: NUM_SINKS must be a power of two");

   assign rsv = (in_id == '0) || (in_id >= RSV_BASE);

   for (genvar s = 0; s < NUM_SINKS; s++) begin : g_sink
      tidf_sink_bank #(
         .NUM_IDS (NUM_IDS),
         .REG_W   (REG_W),
         .CNT_W   (CNT_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd_hit   (cmd_valid && cmd_sink == SINK_W'(s)),
         .cmd_en    (cmd_op == OP_ENABLE),
         .cmd_id    (cmd_id),
         .wr_hit    (reg_we && reg_addr[ADDR_W-1 -: SINK_W] == SINK_W'(s)),
         .wr_word   (reg_addr[WSEL_W-1:0]),
         .wr_data   (reg_wdata),
         .map       (map_s[s]),
         .err_pulse (err_s[s])
      );
      assign pass[s] = map_s[s][in_id] && !rsv;
   end

   tidf_fork #(.N(NUM_SINKS)) u_fork (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .pass      (pass),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .out_valid (out_valid)
   );

   assign out_id   = in_id;
   assign out_data = in_data;

   assign rd_sink   = reg_addr[ADDR_W-1 -: SINK_W];
   assign rd_word   = reg_addr[WSEL_W-1:0];
   assign reg_rdata = map_s[rd_sink][rd_word*REG_W +: REG_W];

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (|err_s)
         err_q <= 1'b1;
   end
   assign err_flag = err_q;

   // R8: the error flag never drops without reset
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R9: reserved IDs never reach a sink
   p_no_rsv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid != '0 |-> (in_id != '0 && in_id < RSV_BASE));

   // R9: a reserved ID never stalls the input
   p_rsv_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_id == '0 || in_id >= RSV_BASE) |-> in_ready);
endmodule

// File: tb/trace_id_filter_test.sv
`timescale 1ns/100ps
module trace_id_filter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmd_valid = 1'b0;
   logic        cmd_op = 1'b0;
   logic        cmd_sink = 1'b0;
   logic [6:0]  cmd_id = '0;
   logic        err_flag;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [6:0]  in_id = '0;
   logic [31:0] in_data = '0;
   logic [1:0]  out_valid;
   logic [1:0]  out_ready = '0;
   logic [6:0]  out_id;
   logic [31:0] out_data;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   trace_id_filter uut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sink(cmd_sink), .cmd_id(cmd_id),
      .err_flag(err_flag),
      .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_data(out_data)
   );

   // beat vectors: {id, out_ready, expected out_valid, expected in_ready}
   localparam int NV = 11;
   localparam logic [11:0] VEC [NV] = '{
      {7'd5,    2'b11, 2'b11, 1'b1},  // R4 both sinks
      {7'd5,    2'b01, 2'b00, 1'b0},  // R5 sink1 busy
      {7'd5,    2'b10, 2'b00, 1'b0},  // R5 sink0 busy
      {7'h40,   2'b11, 2'b10, 1'b1},  // R3 sink1 only
      {7'h40,   2'b01, 2'b00, 1'b0},  // R5 accepting sink busy
      {7'h60,   2'b11, 2'b01, 1'b1},  // R3 sink0 via written word
      {7'h70,   2'b00, 2'b00, 1'b1},  // R9 reserved low edge
      {7'h7F,   2'b00, 2'b00, 1'b1},  // R9 reserved top
      {7'h00,   2'b00, 2'b00, 1'b1},  // R9 id zero
      {7'd7,    2'b00, 2'b00, 1'b1},  // R5 dropped, no stall
      {7'h6F,   2'b10, 2'b00, 1'b0}   // R5 sink0 busy on high id
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_cmd(input logic op, input logic sink, input logic [6:0] id);
      cmd_valid = 1'b1; cmd_op = op; cmd_sink = sink; cmd_id = id;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   initial begin
      #(40000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) rd_check("R1", 3'(a), 32'h0);
      check("R1 err", {31'b0, err_flag}, 32'h0);
      in_valid = 1'b1; in_id = 7'd5; out_ready = 2'b00;
      #1;
      check("R1 ready", {31'b0, in_ready}, 32'h1);
      check("R1 valid", {30'b0, out_valid}, 32'h0);
      in_valid = 1'b0;
      @(negedge clk);

      // setup
      do_cmd(1'b1, 1'b0, 7'd5);
      do_cmd(1'b1, 1'b1, 7'd5);
      do_cmd(1'b1, 1'b1, 7'h40);
      do_wr(3'd0, 32'h0000_0021);
      do_wr(3'd3, 32'hFFFF_FFFF);
      rd_check("R2 s0w0", 3'd0, 32'h0000_0021);
      rd_check("R6 s1w0", 3'd4, 32'h0000_0020);
      rd_check("R6 s1w2", 3'd6, 32'h0000_0001);
      rd_check("R2 s0w3", 3'd3, 32'hFFFF_FFFF);
      rd_check("R2 s1w1", 3'd5, 32'h0);

      // table of beats (R3, R4, R5, R9)
      for (int v = 0; v < NV; v++) begin
         in_valid  = 1'b1;
         in_id     = VEC[v][11:5];
         out_ready = VEC[v][4:3];
         in_data   = 32'hA500_0000 + 32'(v);
         #1;
         check("R3/R4/R5/R9 valid", {30'b0, out_valid}, {30'b0, VEC[v][2:1]});
         check("R5 ready", {31'b0, in_ready}, {31'b0, VEC[v][0]});
         if (VEC[v][2:1] != 2'b00) begin
            check("R3 data", out_data, 32'hA500_0000 + 32'(v));
            check("R3 id", {25'b0, out_id}, {25'b0, VEC[v][11:5]});
         end
         @(negedge clk);
      end
      in_valid = 1'b0; out_ready = 2'b00;

      // R7 two enables need two disables
      do_cmd(1'b1, 1'b0, 7'd9);
      do_cmd(1'b1, 1'b0, 7'd9);
      rd_check("R6 set", 3'd0, 32'h0000_0221);
      do_cmd(1'b0, 1'b0, 7'd9);
      rd_check("R7 held", 3'd0, 32'h0000_0221);
      do_cmd(1'b0, 1'b0, 7'd9);
      rd_check("R7 cleared", 3'd0, 32'h0000_0021);

      // R10 register write leaves the count
      do_cmd(1'b1, 1'b0, 7'd12);
      do_wr(3'd0, 32'h0000_0021);
      rd_check("R10 wr clear", 3'd0, 32'h0000_0021);
      do_cmd(1'b1, 1'b0, 7'd12);
      do_cmd(1'b0, 1'b0, 7'd12);
      rd_check("R10 count kept", 3'd0, 32'h0000_1021);
      do_cmd(1'b0, 1'b0, 7'd12);
      rd_check("R10 final", 3'd0, 32'h0000_0021);

      // R11 same-cycle command and write
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_0021;
      cmd_valid = 1'b1; cmd_op = 1'b1; cmd_sink = 1'b0; cmd_id = 7'd20;
      @(negedge clk);
      reg_we = 1'b0; cmd_valid = 1'b0;
      rd_check("R11 write wins", 3'd0, 32'h0000_0021);
      do_cmd(1'b0, 1'b0, 7'd20);
      check("R11 count taken", {31'b0, err_flag}, 32'h0);

      // R6 saturation at 255
      for (int i = 0; i < 256; i++) do_cmd(1'b1, 1'b1, 7'd10);
      rd_check("R6 sat set", 3'd4, 32'h0000_0420);
      for (int i = 0; i < 254; i++) do_cmd(1'b0, 1'b1, 7'd10);
      rd_check("R6 sat held", 3'd4, 32'h0000_0420);
      do_cmd(1'b0, 1'b1, 7'd10);
      rd_check("R6 sat cleared", 3'd4, 32'h0000_0020);
      check("R6 no err", {31'b0, err_flag}, 32'h0);

      // R8 disable at zero
      do_cmd(1'b0, 1'b0, 7'd9);
      check("R8 err", {31'b0, err_flag}, 32'h1);
      rd_check("R8 map kept", 3'd0, 32'h0000_0021);
      repeat (4) @(negedge clk);
      check("R8 sticky", {31'b0, err_flag}, 32'h1);

      // R10 bit set by write with zero count
      do_wr(3'd4, 32'h0000_00A0);
      do_cmd(1'b0, 1'b1, 7'd7);
      rd_check("R10 zero-count bit", 3'd4, 32'h0000_00A0);
      in_valid = 1'b1; in_id = 7'd7; out_ready = 2'b10;
      #1;
      check("R3 written id", {30'b0, out_valid}, 32'h2);
      in_valid = 1'b0;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule